// File: doc/BRIEF.md
# Chained Descriptor Transfer Sequencer

This block pairs a data channel with a control channel so that fixed-size blocks can be sent to a series of scattered destinations without help from software. The data channel does not move any data here. Its transfer is modelled as a countdown of the transfer count. It has a read address, a write address, a transfer count and a control word. Each of these can be written through four alias views, and each view places the fields in a different order. A write to the last slot of a view starts the channel. There are no shadow copies of the data-channel registers. A register can only be changed while the channel is idle, and any write that arrives while a block is running is discarded.

The control channel walks a list of 32-bit words held in memory. Each word is the destination of one block. The control channel fetches a word and writes it into the slot of the view whose trigger is the write address. This reprograms the data channel and restarts it. The control channel takes control again whenever a block finishes with its chain bit set.

The list ends in one of two ways. It can end at a zero word, which stops the sequence instead of starting a block. It can also run as a perpetual ring, where the list pointer wraps back to the first entry after a programmed length. Only word alignment is required of any block.

Top module: `sg_dma_seq`

## Requirements
- R1: After reset, dch_busy, dch_start, seq_busy, seq_done and mem_req are 0, blk_count is 0, and all four data-channel fields read 0.
- R2: Data-channel slots sit at cfg_addr 0..15. Bits [3:2] select the view and bits [1:0] the slot. The field order per view is: view 0: read, write, count, control. View 1: control, read, write, count. View 2: control, count, read, write. View 3: control, write, count, read. A write to slot 3 of a view stores the field and, if the written value is nonzero, starts a block. Writes to slots 0..2 only store the field.
- R3: A started block raises dch_start for exactly one cycle, and dch_busy stays high for max(count,1) cycles.
- R4: When a block ends with control bit 0 set, mem_req is high in the next cycle. mem_addr then equals list base + 4 × list index, with the index starting at 0 after a go command.
- R5: Between the end of a chained block and the start of the next, dch_busy is low for exactly 2 cycles. The idle_gap output reports 2.
- R6: A zero list word causes no start. seq_done rises 2 cycles after the fetch, seq_busy falls, and blk_count stops counting.
- R7: When the loop bit (bit 0 of cfg_addr 18) is set, the list index wraps to 0 after list length entries (cfg_addr 17). When the bit is cleared, the index keeps counting up until it reaches a zero word.
- R8: While dch_busy is high, writes to any data-channel slot are ignored, triggers included.
- R9: The read and write addresses are stored with bits [1:0] forced to zero.
- R10: blk_count increments by one each time a block finishes.
- R11: The list base is written at cfg_addr 16 and is word-aligned. A write to cfg_addr 19 while the block is idle starts the list walk and clears seq_done.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| cfg_we | input | 1 | Register write strobe |
| cfg_addr | input | 5 | Register word index |
| cfg_wdata | input | DW | Register write data |
| mem_req | output | 1 | List read request |
| mem_addr | output | DW | List read byte address |
| mem_rdata | input | DW | List word, valid the cycle after mem_req |
| dch_start | output | 1 | One-cycle pulse when a block starts |
| dch_busy | output | 1 | Data channel counting down |
| dch_raddr | output | DW | Data-channel read address |
| dch_waddr | output | DW | Data-channel write address |
| dch_count | output | DW | Data-channel transfer count |
| dch_ctrl | output | DW | Data-channel control word, bit 0 chains |
| seq_busy | output | 1 | Sequence or block in progress |
| seq_done | output | 1 | List ended on a zero word |
| blk_count | output | BW | Finished block counter |
| idle_gap | output | 4 | Fixed idle cycles between chained blocks |

## Verification
Each result has a fixed due cycle:
- A trigger write is seen as dch_start and dch_busy right after the edge that takes the write.
- dch_busy falls count cycles later.
- mem_req appears in the first cycle after the fall.
- The next start, or seq_done, follows two cycles after mem_req.

The bench drives inputs and samples outputs on the falling edge. During list runs it logs the cycle index of every start against the go write, so the 2-cycle gap and the block period of count+2 are compared as exact numbers rather than waited for.

// File: rtl/sg_dma_seq.sv
module sg_dma_seq #(
  parameter int DW = 32,
  parameter int BW = 16,
  parameter int IW = 16
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          cfg_we,
  input  logic [4:0]    cfg_addr,
  input  logic [DW-1:0] cfg_wdata,
  output logic          mem_req,
  output logic [DW-1:0] mem_addr,
  input  logic [DW-1:0] mem_rdata,
  output logic          dch_start,
  output logic          dch_busy,
  output logic [DW-1:0] dch_raddr,
  output logic [DW-1:0] dch_waddr,
  output logic [DW-1:0] dch_count,
  output logic [DW-1:0] dch_ctrl,
  output logic          seq_busy,
  output logic          seq_done,
  output logic [BW-1:0] blk_count,
  output logic [3:0]    idle_gap
);
  localparam logic [4:0] A_BASE = 5'd16;
  localparam logic [4:0] A_LEN  = 5'd17;
  localparam logic [4:0] A_MODE = 5'd18;
  localparam logic [4:0] A_GO   = 5'd19;
  localparam logic [4:0] A_SEQ  = 5'd11;
  localparam logic [1:0] F_RD = 2'd0, F_WR = 2'd1, F_CNT = 2'd2, F_CTL = 2'd3;

  typedef enum logic [1:0] {C_IDLE, C_FETCH, C_LOAD} cst_t;

  cst_t          cst;
  logic [DW-1:0] raddr_q, waddr_q, cnt_q, ctl_q, rem_q, base_q;
  logic [IW-1:0] len_q, idx_q;
  logic          loop_q, busy_q, start_q, done_q;
  logic [BW-1:0] blk_q;
  logic [1:0]    fld;

  wire           loading = (cst == C_LOAD);
  wire  [4:0]    w_addr  = loading ? A_SEQ : cfg_addr;
  wire  [DW-1:0] w_data  = loading ? mem_rdata : cfg_wdata;
  wire  [DW-1:0] w_align = {w_data[DW-1:2], 2'b00};
  wire           w_dch   = (loading | cfg_we) & ~w_addr[4] & ~busy_q;
  wire           w_trig  = w_dch & (w_addr[1:0] == 2'd3);
  wire           launch  = w_trig & (w_data != '0);
  wire           sw_ctl  = cfg_we & ~loading & cfg_addr[4];
  wire           go      = sw_ctl & (cfg_addr == A_GO) & (cst == C_IDLE) & ~busy_q;
  wire           fin     = busy_q & (rem_q <= DW'(1));
  wire  [IW:0]   idx_inc = {1'b0, idx_q} + 1'b1;
  wire           wrap    = loop_q & (idx_inc >= {1'b0, len_q});
  wire  [DW-1:0] new_cnt = (fld == F_CNT) ? w_data : cnt_q;

  always_comb begin
    case (w_addr[3:0])
      4'd0:  fld = F_RD;
      4'd1:  fld = F_WR;
      4'd2:  fld = F_CNT;
      4'd3:  fld = F_CTL;
      4'd4:  fld = F_CTL;
      4'd5:  fld = F_RD;
      4'd6:  fld = F_WR;
      4'd7:  fld = F_CNT;
      4'd8:  fld = F_CTL;
      4'd9:  fld = F_CNT;
      4'd10: fld = F_RD;
      4'd11: fld = F_WR;
      4'd12: fld = F_CTL;
      4'd13: fld = F_WR;
      4'd14: fld = F_CNT;
      default: fld = F_RD;
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      raddr_q <= '0;
      waddr_q <= '0;
      cnt_q   <= '0;
      ctl_q   <= '0;
      rem_q   <= '0;
      busy_q  <= 1'b0;
      start_q <= 1'b0;
      blk_q   <= '0;
    end else begin
      if (w_dch) begin
        case (fld)
          F_RD:    raddr_q <= w_align;
          F_WR:    waddr_q <= w_align;
          F_CNT:   cnt_q   <= w_data;
          default: ctl_q   <= w_data;
        endcase
      end
      start_q <= launch;
      if (launch) begin
        busy_q <= 1'b1;
        rem_q  <= new_cnt;
      end else if (fin) begin
        busy_q <= 1'b0;
        blk_q  <= blk_q + 1'b1;
      end else if (busy_q) begin
        rem_q  <= rem_q - 1'b1;
      end
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      cst    <= C_IDLE;
      base_q <= '0;
      len_q  <= '0;
      idx_q  <= '0;
      loop_q <= 1'b0;
      done_q <= 1'b0;
    end else begin
      if (sw_ctl && cfg_addr == A_BASE) base_q <= {cfg_wdata[DW-1:2], 2'b00};
      if (sw_ctl && cfg_addr == A_LEN)  len_q  <= cfg_wdata[IW-1:0];
      if (sw_ctl && cfg_addr == A_MODE) loop_q <= cfg_wdata[0];
      case (cst)
        C_IDLE: begin
          if (go) begin
            cst    <= C_FETCH;
            idx_q  <= '0;
            done_q <= 1'b0;
          end else if (fin && ctl_q[0]) begin
            cst <= C_FETCH;
          end
        end
        C_FETCH: begin
          cst   <= C_LOAD;
          idx_q <= wrap ? '0 : idx_inc[IW-1:0];
        end
        default: begin
          cst <= C_IDLE;
          if (mem_rdata == '0) done_q <= 1'b1;
        end
      endcase
    end
  end

  assign mem_req   = (cst == C_FETCH);
  assign mem_addr  = base_q + (DW'(idx_q) << 2);
  assign dch_start = start_q;
  assign dch_busy  = busy_q;
  assign dch_raddr = raddr_q;
  assign dch_waddr = waddr_q;
  assign dch_count = cnt_q;
  assign dch_ctrl  = ctl_q;
  assign seq_busy  = (cst != C_IDLE) | busy_q;
  assign seq_done  = done_q;
  assign blk_count = blk_q;
  assign idle_gap  = 4'd2;
endmodule

// File: rtl/sg_dma_seq_chk.sv
module sg_dma_seq_chk #(
  parameter int DW = 32,
  parameter int BW = 16
) (
  input logic          clk,
  input logic          rst_n,
  input logic          dch_start,
  input logic          dch_busy,
  input logic [DW-1:0] dch_waddr,
  input logic [DW-1:0] dch_count,
  input logic [DW-1:0] dch_ctrl,
  input logic          mem_req,
  input logic          seq_done,
  input logic [BW-1:0] blk_count
);
  a_r3_start_busy: assert property (@(posedge clk) disable iff (!rst_n)
    dch_start |-> dch_busy);

  a_r3_start_single: assert property (@(posedge clk) disable iff (!rst_n)
    dch_start |=> !dch_start);

  a_r8_frozen_busy: assert property (@(posedge clk) disable iff (!rst_n)
    (dch_busy && !dch_start) |-> ($stable(dch_waddr) && $stable(dch_count) && $stable(dch_ctrl)));

  a_r4_chain_fetch: assert property (@(posedge clk) disable iff (!rst_n)
    ($fell(dch_busy) && dch_ctrl[0]) |-> mem_req);

  a_r5_two_cycle_gap: assert property (@(posedge clk) disable iff (!rst_n)
    mem_req |-> ##2 (dch_start || seq_done));

  a_r6_end_quiet: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(seq_done) |-> (!dch_busy && !mem_req));

  a_r10_count_step: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(dch_busy) |-> (blk_count == BW'($past(blk_count) + 1'b1)));
endmodule

bind sg_dma_seq sg_dma_seq_chk #(.DW(DW), .BW(BW)) u_chk (
  .clk(clk), .rst_n(rst_n), .dch_start(dch_start), .dch_busy(dch_busy),
  .dch_waddr(dch_waddr), .dch_count(dch_count), .dch_ctrl(dch_ctrl),
  .mem_req(mem_req), .seq_done(seq_done), .blk_count(blk_count)
);

// File: tb/test_sg_dma_seq.sv
module test_sg_dma_seq;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        cfg_we = 1'b0;
  logic [4:0]  cfg_addr = '0;
  logic [31:0] cfg_wdata = '0;
  logic        mem_req;
  logic [31:0] mem_addr;
  logic [31:0] mem_rdata = '0;
  logic        dch_start, dch_busy, seq_busy, seq_done;
  logic [31:0] dch_raddr, dch_waddr, dch_count, dch_ctrl;
  logic [15:0] blk_count;
  logic [3:0]  idle_gap;
  logic [31:0] mem [64];
  int checks = 0;
  int failures = 0;

  always #2 clk = ~clk;

  sg_dma_seq i_sg_dma_seq (
    .clk(clk), .rst_n(rst_n), .cfg_we(cfg_we), .cfg_addr(cfg_addr), .cfg_wdata(cfg_wdata),
    .mem_req(mem_req), .mem_addr(mem_addr), .mem_rdata(mem_rdata),
    .dch_start(dch_start), .dch_busy(dch_busy), .dch_raddr(dch_raddr), .dch_waddr(dch_waddr),
    .dch_count(dch_count), .dch_ctrl(dch_ctrl), .seq_busy(seq_busy), .seq_done(seq_done),
    .blk_count(blk_count), .idle_gap(idle_gap)
  );

  always @(posedge clk) if (mem_req) mem_rdata <= mem[mem_addr[7:2]];

  // addr, data, expect start, field (0 rd,1 wr,2 cnt,3 ctl), expected field value
  localparam logic [71:0] VEC [17] = '{
    {5'd0,  32'h1003, 1'b0, 2'd0, 32'h1000},
    {5'd1,  32'h2006, 1'b0, 2'd1, 32'h2004},
    {5'd2,  32'd4,    1'b0, 2'd2, 32'd4},
    {5'd3,  32'd0,    1'b0, 2'd3, 32'd0},
    {5'd3,  32'h10,   1'b1, 2'd3, 32'h10},
    {5'd4,  32'h20,   1'b0, 2'd3, 32'h20},
    {5'd5,  32'h3000, 1'b0, 2'd0, 32'h3000},
    {5'd6,  32'h4001, 1'b0, 2'd1, 32'h4000},
    {5'd7,  32'd2,    1'b1, 2'd2, 32'd2},
    {5'd8,  32'h40,   1'b0, 2'd3, 32'h40},
    {5'd9,  32'd1,    1'b0, 2'd2, 32'd1},
    {5'd10, 32'h5000, 1'b0, 2'd0, 32'h5000},
    {5'd11, 32'h6000, 1'b1, 2'd1, 32'h6000},
    {5'd12, 32'h80,   1'b0, 2'd3, 32'h80},
    {5'd13, 32'h7000, 1'b0, 2'd1, 32'h7000},
    {5'd14, 32'd0,    1'b0, 2'd2, 32'd0},
    {5'd15, 32'h8000, 1'b1, 2'd0, 32'h8000}
  };

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      failures++;
      $display("FAIL %s actual=0x%0h expected=0x%0h", req, act, exp);
    end
  endtask

  task automatic wr(input logic [4:0] a, input logic [31:0] d);
    @(negedge clk);
    cfg_we = 1'b1; cfg_addr = a; cfg_wdata = d;
    @(negedge clk);
    cfg_we = 1'b0;
  endtask

  task automatic wait_idle();
    for (int i = 0; i < 50 && dch_busy; i++) @(negedge clk);
  endtask

  function automatic logic [31:0] pick(input logic [1:0] f);
    case (f)
      2'd0: pick = dch_raddr;
      2'd1: pick = dch_waddr;
      2'd2: pick = dch_count;
      default: pick = dch_ctrl;
    endcase
  endfunction

  initial begin
    #(4 * 20000);
    failures++;
    $display("FAIL watchdog actual=0x0 expected=0x1");
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    int ns, low, bc;
    int st_cyc [8];
    logic [31:0] st_wa [8];
    for (int i = 0; i < 64; i++) mem[i] = '0;
    mem[16] = 32'h1000; mem[17] = 32'h1100; mem[18] = 32'h1200; mem[19] = 32'h0;
    mem[32] = 32'h2000; mem[33] = 32'h2400; mem[34] = 32'h0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);

    // R1 reset state
    check("R1 busy", {31'b0, dch_busy}, 32'd0);
    check("R1 start", {31'b0, dch_start}, 32'd0);
    check("R1 seq_busy", {31'b0, seq_busy}, 32'd0);
    check("R1 done", {31'b0, seq_done}, 32'd0);
    check("R1 mem_req", {31'b0, mem_req}, 32'd0);
    check("R1 blk_count", {16'b0, blk_count}, 32'd0);
    check("R1 fields", dch_raddr | dch_waddr | dch_count | dch_ctrl, 32'd0);

    // R2 / R9: alias table walk
    for (int v = 0; v < 17; v++) begin
      wr(VEC[v][71:67], VEC[v][66:35]);
      check("R2 start", {31'b0, dch_start}, {31'b0, VEC[v][34]});
      check("R2/R9 field", pick(VEC[v][33:32]), VEC[v][31:0]);
      wait_idle();
    end
    check("R10 blocks after table", {16'b0, blk_count}, 32'd4);

    // R3 busy length and single start pulse
    wr(5'd2, 32'd5);
    wr(5'd3, 32'h10);
    bc = 0;
    check("R3 pulse", {31'b0, dch_start}, 32'd1);
    for (int i = 0; i < 20 && dch_busy; i++) begin
      bc++;
      @(negedge clk);
      if (i == 0) check("R3 pulse width", {31'b0, dch_start}, 32'd0);
    end
    check("R3 busy cycles", bc, 32'd5);

    // R8 writes during busy are ignored
    wr(5'd2, 32'd6);
    wr(5'd3, 32'h10);
    wr(5'd1, 32'h9000);
    wr(5'd3, 32'h30);
    check("R8 waddr kept", dch_waddr, 32'h7000);
    check("R8 ctrl kept", dch_ctrl, 32'h10);
    wait_idle();
    check("R8 count kept", dch_count, 32'd6);
    check("R10 one block", {16'b0, blk_count}, 32'd6);

    // R4 R5 R6 R11 linear list ending on zero
    wr(5'd2, 32'd3);
    wr(5'd4, 32'h1);
    wr(5'd16, 32'h43);
    wr(5'd17, 32'd4);
    wr(5'd18, 32'd0);
    bc = blk_count;
    wr(5'd19, 32'd1);
    check("R4 first fetch req", {31'b0, mem_req}, 32'd1);
    check("R11 base aligned", mem_addr, 32'h40);
    check("R5 gap port", {28'b0, idle_gap}, 32'd2);
    ns = 0; low = 0;
    for (int k = 0; k < 40; k++) begin
      if (dch_start && ns < 8) begin st_cyc[ns] = k; st_wa[ns] = dch_waddr; ns++; end
      if (ns >= 1 && ns < 3 && !dch_busy) low++;
      if (k == 5) check("R4 second fetch addr", mem_addr, 32'h44);
      if (k < 39) @(negedge clk);
    end
    check("R6 starts", ns, 32'd3);
    check("R4 dest 0", st_wa[0], 32'h1000);
    check("R4 dest 1", st_wa[1], 32'h1100);
    check("R4 dest 2", st_wa[2], 32'h1200);
    check("R5 first start", st_cyc[0], 32'd2);
    check("R5 period 1", st_cyc[1] - st_cyc[0], 32'd5);
    check("R5 period 2", st_cyc[2] - st_cyc[1], 32'd5);
    check("R5 idle cycles", low, 32'd4);
    check("R6 done", {31'b0, seq_done}, 32'd1);
    check("R6 seq_busy", {31'b0, seq_busy}, 32'd0);
    check("R10 list blocks", blk_count - bc, 32'd3);

    // R7 loop ring then run off to the zero word
    wr(5'd2, 32'd2);
    wr(5'd16, 32'h80);
    wr(5'd17, 32'd2);
    wr(5'd18, 32'd1);
    wr(5'd19, 32'd1);
    check("R11 done cleared", {31'b0, seq_done}, 32'd0);
    ns = 0;
    for (int k = 0; k < 18; k++) begin
      if (dch_start && ns < 8) begin st_wa[ns] = dch_waddr; ns++; end
      if (k < 17) @(negedge clk);
    end
    check("R7 ring starts", ns, 32'd4);
    check("R7 ring 0", st_wa[0], 32'h2000);
    check("R7 ring 1", st_wa[1], 32'h2400);
    check("R7 ring wrap", st_wa[2], 32'h2000);
    check("R7 ring 3", st_wa[3], 32'h2400);
    check("R7 no end in ring", {31'b0, seq_done}, 32'd0);
    wr(5'd18, 32'd0);
    for (int k = 0; k < 30 && !seq_done; k++) @(negedge clk);
    check("R7 ends after loop off", {31'b0, seq_done}, 32'd1);
    check("R6 idle after end", {31'b0, seq_busy}, 32'd0);

    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule